// File: doc/BRIEF.md
# Next-Block Prefetch Sequencer

This block sits next to a cache tag controller and extends each demand miss with a short burst of prefetch probes. When the controller reports a demand access that missed, the sequencer walks forward through the block addresses that follow the missing block. It presents one probe per cycle on the controller's prefetch fill port. The controller answers each probe in the same cycle with a presence flag. A present block leaves the cache, its statistics and its replacement order untouched. An absent block is allocated like a demand fill, with a victim chosen and one memory read counted.

The burst length comes from a runtime input. It is sampled once, when the triggering miss is accepted, and is capped at a build-time maximum. A length of zero turns prefetching off. While a burst is in flight the sequencer drops its demand-ready output, so the controller accepts no new demand request until the last probe has been issued. Block size and address width are parameters, and probe addresses wrap modulo the address space.

Top module: `next_block_prefetcher`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `dmd_ready_o` is 1 and `busy_o`, `probe_valid_o`, `probe_fill_o` and `probe_last_o` are 0.
- R2: A demand access reported as a hit (`dmd_hit_i`=1), or a demand miss arriving while `depth_i` is 0, starts no burst: `probe_valid_o` and `busy_o` stay 0.
- R3: A demand miss accepted while `dmd_ready_o`=1 and `depth_i`>0 raises `busy_o` in that same cycle. Probes then appear in the following cycle, one per cycle, for exactly the effective depth in consecutive cycles.
- R4: Probe k (k = 1 .. N) carries address `((dmd_addr >> OFF) + k) << OFF` modulo 2^ADDR_W, where OFF = log2(block bytes). The low OFF bits are always zero.
- R5: A probe answered with `probe_hit_i`=1 leaves `probe_fill_o` at 0 in that cycle, so there is no allocation, no memory-read count and no replacement update.
- R6: A probe answered with `probe_hit_i`=0 raises `probe_fill_o` for that cycle, so the block is allocated as a demand fill and one memory read is counted.
- R7: `dmd_ready_o` is 0 and `busy_o` is 1 in every probe cycle. Both return to 1 and 0 in the cycle after the last probe. Demand inputs presented while `dmd_ready_o`=0 are ignored, so the burst length and its addresses do not change.
- R8: The depth is captured when the burst starts. Changes to `depth_i` during the burst do not change its length.
- R9: A `depth_i` above MAX_DEPTH (default 15) produces exactly MAX_DEPTH probes.
- R10: `probe_last_o` is 1 only together with the final probe of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| dmd_valid_i | input | 1 | Controller reports a demand access this cycle |
| dmd_hit_i | input | 1 | That demand access hit the cache |
| dmd_addr_i | input | ADDR_W (48) | Byte address of the demand access |
| depth_i | input | DIN_W (8) | Number of following blocks to probe |
| dmd_ready_o | output | 1 | Controller may accept a new demand request |
| busy_o | output | 1 | A burst is starting or in progress |
| probe_valid_o | output | 1 | A prefetch probe is presented |
| probe_addr_o | output | ADDR_W (48) | Block-aligned probe address |
| probe_hit_i | input | 1 | Probed block is already cached (same cycle) |
| probe_fill_o | output | 1 | Allocate the probed block and count a memory read |
| probe_last_o | output | 1 | This probe is the final one of the burst |

## Verification
The end of one burst and the start of the next can fall in adjacent cycles, and a demand miss can arrive during the final probe cycle itself. The bench raises a demand miss during the final probe and checks that it is ignored. It then presents a fresh miss in the first cycle that `dmd_ready_o` is high again and checks that the new burst starts one cycle later with addresses from the new base. The old burst must not leak into the new one. A second overlap is tested by flipping `probe_hit_i` on each probe: fill decisions are judged per cycle against the hit pattern while the address keeps advancing.

// File: rtl/pf_seq_pkg.sv
package pf_seq_pkg;

    typedef enum logic [0:0] {
        PF_IDLE = 1'b0,
        PF_RUN  = 1'b1
    } pf_state_e;

endpackage

// File: rtl/pf_seq_ctrl.sv
module pf_seq_ctrl
    import pf_seq_pkg::*;
#(
    parameter int unsigned DIN_W     = 8,
    parameter int unsigned MAX_DEPTH = 15,
    parameter int unsigned CNT_W     = $clog2(MAX_DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             dmd_valid_i,
    input  logic             dmd_hit_i,
    input  logic [DIN_W-1:0] depth_i,
    output logic             ready_o,
    output logic             busy_o,
    output logic             trigger_o,
    output logic             probe_o,
    output logic             last_o
);

    localparam logic [DIN_W-1:0] MAX_IN  = DIN_W'(MAX_DEPTH);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_DEPTH);

    typedef struct packed {
        pf_state_e        state;
        logic [CNT_W-1:0] remain;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic [CNT_W-1:0] eff_depth;
    logic             trigger;

    always_comb begin
        eff_depth = (depth_i > MAX_IN) ? MAX_CNT : CNT_W'(depth_i);
        trigger   = (ctrl_q.state == PF_IDLE) && dmd_valid_i && !dmd_hit_i
                    && (depth_i != '0);
        ctrl_d    = ctrl_q;
        unique case (ctrl_q.state)
            PF_IDLE: begin
                if (trigger) begin
                    ctrl_d.state  = PF_RUN;
                    ctrl_d.remain = eff_depth;
                end
            end
            PF_RUN: begin
                ctrl_d.remain = ctrl_q.remain - 1'b1;
                if (ctrl_q.remain == CNT_W'(1)) begin
                    ctrl_d.state = PF_IDLE;
                end
            end
            default: ctrl_d.state = PF_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctrl_q <= '{state: PF_IDLE, remain: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ready_o   = (ctrl_q.state == PF_IDLE);
    assign probe_o   = (ctrl_q.state == PF_RUN);
    assign last_o    = probe_o && (ctrl_q.remain == CNT_W'(1));
    assign trigger_o = trigger;
    assign busy_o    = probe_o || trigger;

    // R3
    trigger_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trigger |=> probe_o);

    // R10
    last_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        last_o |=> (!probe_o && ready_o));

    // R7
    no_ready_in_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        probe_o |-> !ready_o);

    // R2
    hit_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && dmd_valid_i && dmd_hit_i) |=> !probe_o);

endmodule

// File: rtl/pf_addr_gen.sv
module pf_addr_gen #(
    parameter int unsigned ADDR_W = 48,
    parameter int unsigned OFF_W  = 2,
    parameter int unsigned BLK_W  = ADDR_W - OFF_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    output logic [ADDR_W-1:0] probe_addr_o
);

    typedef struct packed {
        logic [BLK_W-1:0] blk;
    } agen_t;

    agen_t agen_d, agen_q;

    always_comb begin
        agen_d = agen_q;
        if (load_i) begin
            agen_d.blk = base_addr_i[ADDR_W-1:OFF_W] + 1'b1;
        end else if (adv_i) begin
            agen_d.blk = agen_q.blk + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            agen_q <= '0;
        end else begin
            agen_q <= agen_d;
        end
    end

    generate
        if (OFF_W == 0) begin : g_no_off
            assign probe_addr_o = agen_q.blk;
        end else begin : g_off
            assign probe_addr_o = {agen_q.blk, {OFF_W{1'b0}}};
        end
    endgenerate

    // R4
    addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && !load_i) |=> (agen_q.blk == $past(agen_q.blk) + 1'b1));

endmodule

// File: rtl/next_block_prefetcher.sv
module next_block_prefetcher #(
    parameter int unsigned ADDR_W      = 48,
    parameter int unsigned BLOCK_BYTES = 4,
    parameter int unsigned DIN_W       = 8,
    parameter int unsigned MAX_DEPTH   = 15
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              dmd_valid_i,
    input  logic              dmd_hit_i,
    input  logic [ADDR_W-1:0] dmd_addr_i,
    input  logic [DIN_W-1:0]  depth_i,
    output logic              dmd_ready_o,
    output logic              busy_o,
    output logic              probe_valid_o,
    output logic [ADDR_W-1:0] probe_addr_o,
    input  logic              probe_hit_i,
    output logic              probe_fill_o,
    output logic              probe_last_o
);

    localparam int unsigned OFF_W = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 0;
    localparam int unsigned CNT_W = $clog2(MAX_DEPTH + 1);

    logic trigger;
    logic probe;

    pf_seq_ctrl #(
        .DIN_W    (DIN_W),
        .MAX_DEPTH(MAX_DEPTH),
        .CNT_W    (CNT_W)
    ) i_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .dmd_valid_i(dmd_valid_i),
        .dmd_hit_i  (dmd_hit_i),
        .depth_i    (depth_i),
        .ready_o    (dmd_ready_o),
        .busy_o     (busy_o),
        .trigger_o  (trigger),
        .probe_o    (probe),
        .last_o     (probe_last_o)
    );

    pf_addr_gen #(
        .ADDR_W(ADDR_W),
        .OFF_W (OFF_W)
    ) i_agen (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_i      (trigger),
        .adv_i       (probe),
        .base_addr_i (dmd_addr_i),
        .probe_addr_o(probe_addr_o)
    );

    assign probe_valid_o = probe;
    assign probe_fill_o  = probe && !probe_hit_i;

    // R5
    hit_no_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (probe_valid_o && probe_hit_i) |-> !probe_fill_o);

    // R6
    miss_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (probe_valid_o && !probe_hit_i) |-> probe_fill_o);

    // R7
    busy_covers_probe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        probe_valid_o |-> busy_o);

endmodule

// File: tb/test_next_block_prefetcher.sv
`timescale 1ns/1ps
module test_next_block_prefetcher;

    localparam int unsigned AW  = 48;
    localparam int unsigned OFF = 2;
    localparam int unsigned MAXD = 15;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          dmd_valid, dmd_hit, probe_hit;
    logic [AW-1:0] dmd_addr;
    logic [7:0]    depth;
    logic          dmd_ready, busy, probe_valid, probe_fill, probe_last;
    logic [AW-1:0] probe_addr;

    int vectors  = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    next_block_prefetcher i_next_block_prefetcher (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .dmd_valid_i  (dmd_valid),
        .dmd_hit_i    (dmd_hit),
        .dmd_addr_i   (dmd_addr),
        .depth_i      (depth),
        .dmd_ready_o  (dmd_ready),
        .busy_o       (busy),
        .probe_valid_o(probe_valid),
        .probe_addr_o (probe_addr),
        .probe_hit_i  (probe_hit),
        .probe_fill_o (probe_fill),
        .probe_last_o (probe_last)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a, input int k);
        logic [AW-OFF-1:0] b;
        b = a[AW-1:OFF] + (AW-OFF)'(k);
        return {b, {OFF{1'b0}}};
    endfunction

    // Caller is at negedge+1 of an idle cycle.
    task automatic run_seq(input logic [AW-1:0] a, input logic [7:0] d, input int n,
                           input logic [15:0] hitmask, input bit stray, input bit chg_depth);
        dmd_valid = 1'b1; dmd_hit = 1'b0; dmd_addr = a; depth = d; probe_hit = 1'b0;
        #1;
        chk("R3 busy in trigger cycle", busy, 1);
        chk("R3 no probe in trigger cycle", probe_valid, 0);
        @(negedge clk);
        dmd_valid = 1'b0;
        for (int k = 1; k <= n; k++) begin
            probe_hit = hitmask[k-1];
            if (stray) begin
                dmd_valid = 1'b1; dmd_hit = 1'b0; dmd_addr = ~a;
            end
            if (chg_depth) depth = 8'd1;
            #1;
            chk("R3 probe valid", probe_valid, 1);
            chk("R4 probe address", probe_addr, exp_addr(a, k));
            if (hitmask[k-1]) chk("R5 present block no fill", probe_fill, 0);
            else              chk("R6 absent block fill", probe_fill, 1);
            chk("R10 last flag", probe_last, (k == n));
            chk("R7 ready low in burst", dmd_ready, 0);
            chk("R7 busy high in burst", busy, 1);
            @(negedge clk);
        end
        dmd_valid = 1'b0; probe_hit = 1'b0;
        #1;
        chk("R7 burst ended probe", probe_valid, 0);
        chk("R7 ready after burst", dmd_ready, 1);
        chk("R7 busy after burst", busy, 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; dmd_valid = 1'b0; dmd_hit = 1'b0; dmd_addr = '0;
        depth = 8'd0; probe_hit = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 ready in reset", dmd_ready, 1);
        chk("R1 busy in reset", busy, 0);
        chk("R1 probe in reset", probe_valid, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 probe after reset", probe_valid, 0);
        chk("R1 fill after reset", probe_fill, 0);
        chk("R1 last after reset", probe_last, 0);
        chk("R1 ready after reset", dmd_ready, 1);
    endtask

    task automatic t_no_trigger;
        dmd_valid = 1'b1; dmd_hit = 1'b1; dmd_addr = 48'h1000; depth = 8'd4;
        #1;
        chk("R2 hit busy", busy, 0);
        @(negedge clk); dmd_valid = 1'b0; #1;
        chk("R2 hit no probe", probe_valid, 0);
        dmd_valid = 1'b1; dmd_hit = 1'b0; depth = 8'd0;
        #1;
        chk("R2 depth0 busy", busy, 0);
        @(negedge clk); dmd_valid = 1'b0; #1;
        chk("R2 depth0 no probe", probe_valid, 0);
        chk("R2 depth0 ready", dmd_ready, 1);
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_no_trigger();
        run_seq(48'h0000_0009_cb3d40, 8'd1, 1, 16'h0000, 1'b0, 1'b0);   // R3 R6 single
        run_seq(48'h0000_1234_5670, 8'd4, 4, 16'b0101, 1'b0, 1'b0);     // R5 R6 mixed
        run_seq(48'hFFFF_FFFF_FFF4, 8'd5, 5, 16'b1010, 1'b0, 1'b0);     // R4 wrap
        run_seq(48'h0000_0000_2000, 8'd3, 3, 16'h0000, 1'b1, 1'b0);     // R7 stray miss
        // back-to-back: new miss in first ready cycle
        run_seq(48'h0000_0000_8000, 8'd2, 2, 16'h0003, 1'b0, 1'b0);     // R7 R5
        run_seq(48'h0000_0000_4004, 8'd6, 6, 16'h0000, 1'b0, 1'b1);     // R8 depth change
        run_seq(48'h0000_00AB_0000, 8'd200, MAXD, 16'h5555, 1'b0, 1'b0); // R9 clamp
        run_seq(48'h0000_00AB_1000, 8'd15, 15, 16'hFFFF, 1'b0, 1'b0);   // R9 exact max
        @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, failures);
        $finish;
    end

endmodule